// File: doc/BRIEF.md
# Half-Duplex Line Transmitter with Contention Detection

This block sends bytes as framed serial characters over one data line shared with an external master. It is clocked by the serial clock itself. A byte is accepted through a valid/ready handshake. The block builds a twelve-bit character from it and shifts that character out one bit per serial clock. Outgoing levels change on the falling edge, and the line is read back on the rising edge.

The pad is modelled as a push-pull driver with a tri-state enable and a pull-up. Every zero is driven. In a run of ones only the first one is driven, after which the driver lets go and the pull-up keeps the line high. During those released bits the block watches the line. If the line reads low, another device is driving it. The block then reports a collision, drops the character, keeps the driver off and waits in a blocked state. It leaves that state when the receive side reports a break character.

Back-pressure: `tx_ready` is high only while the transmitter is idle. A byte moves across on a rising edge where `tx_valid` and `tx_ready` are both high. While a character is on the line, or while the block waits for a break, `tx_valid` and `tx_data` have no effect.

Top module: `hdtx_line_top`

## Requirements
- R1: After reset, `data_oe`=0, `data_out`=1, `tx_ready`=1, `tx_done`=0 and `collision`=0.
- R2: A byte is accepted on a rising edge with `tx_valid`=1 and `tx_ready`=1. `tx_ready` is 0 from the next cycle until the character ends. `tx_valid` and `tx_data` are ignored while `tx_ready`=0.
- R3: The character has 12 bits, sent in this order: bit 0 is a start bit of 0, bits 1..8 are the data LSB first, bit 9 makes the count of ones across the data and this bit even, and bits 10 and 11 are stop bits of 1. Bit k appears on `data_out` at the (k+1)-th falling edge after acceptance.
- R4: Whenever a 0 bit is being sent, `data_oe`=1.
- R5: When a 1 bit follows a 0 bit in the character, `data_oe`=1. When a 1 bit follows a 1 bit, `data_oe`=0.
- R6: `data_oe` is 0 at all times while idle or while blocked after a collision.
- R7: If `data_in` is 0 at a rising edge while `data_oe`=0 during a character, `collision` is 1 for exactly the next cycle. The character stops, `tx_done` does not pulse, and from the next falling edge `data_oe` stays 0.
- R8: After a collision, `tx_ready` stays 0 and `tx_valid` is ignored until `rx_break`=1 at a rising edge. `tx_ready` is 1 from the cycle after that edge.
- R9: After the rising edge that samples the last stop bit, `tx_done` is 1 for one cycle and `tx_ready` returns to 1 in that same cycle.
- R10: A low `data_in` while `data_oe`=1 does not raise `collision`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock; bits launch on its falling edge and are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_valid | input | 1 | Byte offered for sending |
| tx_ready | output | 1 | Transmitter idle and able to accept a byte |
| tx_data | input | 8 | Byte to send |
| tx_done | output | 1 | One-cycle pulse when a character has gone out completely |
| collision | output | 1 | One-cycle pulse when contention was seen on a released bit |
| rx_break | input | 1 | Receive side saw a break; clears the blocked state |
| data_out | output | 1 | Level offered to the pad driver |
| data_oe | output | 1 | Pad driver enable |
| data_in | input | 1 | Level read back from the pad |

## Verification
The bench uses several data patterns. 0x00 gives a long run of driven zeros. 0xFF gives a long run of ones that must be released after the first. 0xA5 alternates, so every one is a first one and stays driven. A further byte with odd weight flips the parity bit, which separates correct parity from a constant or inverted parity bit and shows where the release begins in the stop bits. Pulling the line low during a released bit must abort the character. Pulling it low during a driven zero must not, and this separates checking during the released bits from checking on every bit. A second offer made in the middle of a character shows that input is ignored while busy.

// File: rtl/hdtx_pkg.sv
package hdtx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_HOLD = 2'd2
  } tx_state_e;
endpackage

// File: rtl/hdtx_frame_pack.sv
// Builds a character: start bit 0, data LSB first, even parity, stop ones.
module hdtx_frame_pack #(
  parameter int DATA_W  = 8,
  parameter int STOP_W  = 2,
  localparam int FRAME_W = DATA_W + STOP_W + 2
) (
  input  logic [DATA_W-1:0]  data,
  output logic [FRAME_W-1:0] frame
);
  logic par;
  always_comb begin
    par   = ^data;
    frame = {{STOP_W{1'b1}}, par, data, 1'b0};
  end
endmodule

// File: rtl/hdtx_seq_ctrl.sv
// Rising-edge sequencer: accepts bytes, steps bits, reads back released bits.
module hdtx_seq_ctrl
  import hdtx_pkg::*;
#(
  parameter int FRAME_W = 12,
  localparam int CNT_W  = $clog2(FRAME_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_valid,
  input  logic [FRAME_W-1:0] frame,
  input  logic               rx_break,
  input  logic               line_in,
  input  logic               driver_on,
  output tx_state_e          state,
  output logic               cur_bit,
  output logic               tx_ready,
  output logic               tx_done,
  output logic               collision
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   idx;
  logic               take;
  logic               clash;

  always_comb begin
    tx_ready = (state == ST_IDLE);
    take     = tx_ready && tx_valid;
    clash    = (state == ST_SEND) && !driver_on && !line_in;
    cur_bit  = shreg[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      shreg     <= '1;
      idx       <= '0;
      tx_done   <= 1'b0;
      collision <= 1'b0;
    end else begin
      tx_done   <= 1'b0;
      collision <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (take) begin
            shreg <= frame;
            idx   <= '0;
            state <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (clash) begin
            collision <= 1'b1;
            shreg     <= '1;
            state     <= ST_HOLD;
          end else if (idx == LAST_IDX) begin
            tx_done <= 1'b1;
            shreg   <= '1;
            state   <= ST_IDLE;
          end else begin
            shreg <= {1'b1, shreg[FRAME_W-1:1]};
            idx   <= idx + 1'b1;
          end
        end
        ST_HOLD: begin
          if (rx_break) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hdtx_pad_drive.sv
// Falling-edge output stage: drives zeros and the first one of a run only.
module hdtx_pad_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic sending,
  input  logic cur_bit,
  output logic data_out,
  output logic data_oe
);
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_out <= 1'b1;
      data_oe  <= 1'b0;
    end else if (!sending) begin
      data_out <= 1'b1;
      data_oe  <= 1'b0;
    end else begin
      data_out <= cur_bit;
      data_oe  <= !cur_bit || !data_out;
    end
  end
endmodule

// File: rtl/hdtx_line_top.sv
module hdtx_line_top
  import hdtx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STOP_W = 2,
  localparam int FRAME_W = DATA_W + STOP_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_done,
  output logic              collision,
  input  logic              rx_break,
  output logic              data_out,
  output logic              data_oe,
  input  logic              data_in
);
  logic [FRAME_W-1:0] frame;
  tx_state_e          state;
  logic               cur_bit;
  logic               sending;

  hdtx_frame_pack #(.DATA_W(DATA_W), .STOP_W(STOP_W)) u_pack (
    .data (tx_data),
    .frame(frame)
  );

  hdtx_seq_ctrl #(.FRAME_W(FRAME_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_valid (tx_valid),
    .frame    (frame),
    .rx_break (rx_break),
    .line_in  (data_in),
    .driver_on(data_oe),
    .state    (state),
    .cur_bit  (cur_bit),
    .tx_ready (tx_ready),
    .tx_done  (tx_done),
    .collision(collision)
  );

  assign sending = (state == ST_SEND);

  hdtx_pad_drive u_pad (
    .clk     (clk),
    .rst_n   (rst_n),
    .sending (sending),
    .cur_bit (cur_bit),
    .data_out(data_out),
    .data_oe (data_oe)
  );
endmodule

// File: rtl/hdtx_line_chk.sv
module hdtx_line_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_valid,
  input logic tx_ready,
  input logic tx_done,
  input logic collision,
  input logic data_out,
  input logic data_oe
);
  p_accept_drops_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  p_zero_driven_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !data_out |-> data_oe);

  p_run_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_out && $past(data_out)) |-> !data_oe);

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && $past(tx_ready)) |-> !data_oe);

  p_collision_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    collision |=> !collision);

  p_collision_no_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    collision |-> (!tx_done && !data_oe && !tx_ready));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (tx_ready && !$past(tx_ready)));
endmodule

bind hdtx_line_top hdtx_line_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .tx_done  (tx_done),
  .collision(collision),
  .data_out (data_out),
  .data_oe  (data_oe)
);

// File: tb/tb_hdtx_line_top.sv
`timescale 1ns/1ps
module tb_hdtx_line_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = '0;
  logic       rx_break = 1'b0;
  logic       ext_low = 1'b0;
  logic       tx_ready, tx_done, collision, data_out, data_oe, data_in;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  // Line model: pull-up, block driver, external master pulling low.
  assign data_in = ext_low ? 1'b0 : (data_oe ? data_out : 1'b1);

  hdtx_line_top dut (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_done(tx_done), .collision(collision),
    .rx_break(rx_break), .data_out(data_out), .data_oe(data_oe),
    .data_in(data_in)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] mk(input logic [7:0] d);
    logic p = 1'b0;
    for (int i = 0; i < 8; i++) p = p ^ d[i];
    return {2'b11, p, d, 1'b0};
  endfunction

  // Sends one byte and checks every bit (R3 level, R4/R5 enable), the
  // busy window (R2) and the completion pulse (R9).
  // noise: offer another byte mid-character; low0: pull line low on start bit.
  task automatic send_chk(input logic [7:0] d, input bit noise, input bit low0);
    logic [11:0] f = mk(d);
    logic prev = 1'b0;
    @(negedge clk);
    tx_data = d; tx_valid = 1'b1;
    @(posedge clk); #1;
    tx_valid = 1'b0;
    chk(tx_ready == 1'b0, "R2 ready low after accept", tx_ready, 0);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk); #1;
      ext_low = low0 && (k == 0);
      if (noise && k == 4) begin tx_data = ~d; tx_valid = 1'b1; end
      if (noise && k == 7) tx_valid = 1'b0;
      chk(data_out == f[k], $sformatf("R3 bit %0d", k), data_out, f[k]);
      chk(data_oe == (!f[k] || !prev), $sformatf("R4/R5 enable bit %0d", k),
          data_oe, (!f[k] || !prev));
      if (k > 0) chk(tx_ready == 1'b0, "R2 busy during character", tx_ready, 0);
      chk(collision == 1'b0, "R10 no collision", collision, 0);
      prev = f[k];
    end
    @(posedge clk); #1;
    ext_low = 1'b0;
    chk(tx_done == 1'b1, "R9 done pulse", tx_done, 1);
    chk(tx_ready == 1'b1, "R9 ready with done", tx_ready, 1);
    @(posedge clk); #1;
    chk(tx_done == 1'b0, "R9 done one cycle", tx_done, 0);
    chk(data_oe == 1'b0, "R6 idle released", data_oe, 0);
  endtask

  task automatic t_reset;
    #1;
    chk(data_oe == 0, "R1 oe", data_oe, 0);
    chk(data_out == 1, "R1 out", data_out, 1);
    chk(tx_ready == 1, "R1 ready", tx_ready, 1);
    chk(tx_done == 0 && collision == 0, "R1 pulses", {tx_done, collision}, 0);
  endtask

  // 0xFF: bit1 driven, bits 2..8 released; pull low during bit 3.
  task automatic t_collision;
    @(negedge clk);
    tx_data = 8'hFF; tx_valid = 1'b1;
    @(posedge clk); #1;
    tx_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
    end
    chk(data_oe == 0, "R5 bit3 released", data_oe, 0);
    ext_low = 1'b1;
    @(posedge clk); #1;
    chk(collision == 1, "R7 collision pulse", collision, 1);
    chk(tx_done == 0, "R7 no done", tx_done, 0);
    ext_low = 1'b0;
    @(negedge clk); #1;
    chk(data_oe == 0, "R7 driver off", data_oe, 0);
    @(posedge clk); #1;
    chk(collision == 0, "R7 pulse one cycle", collision, 0);
    tx_data = 8'h00; tx_valid = 1'b1;
    for (int k = 0; k < 15; k++) begin
      @(negedge clk); #1;
      chk(data_oe == 0 && tx_ready == 0, "R8/R6 blocked until break",
          {data_oe, tx_ready}, 0);
      chk(tx_done == 0, "R8 no character while blocked", tx_done, 0);
    end
    tx_valid = 1'b0;
    rx_break = 1'b1;
    @(posedge clk); #1;
    rx_break = 1'b0;
    chk(tx_ready == 1, "R8 ready after break", tx_ready, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    send_chk(8'h00, 1'b0, 1'b0);
    send_chk(8'hFF, 1'b0, 1'b0);
    send_chk(8'hA5, 1'b0, 1'b0);
    send_chk(8'h07, 1'b0, 1'b0);
    send_chk(8'h3C, 1'b1, 1'b0);
    send_chk(8'h80, 1'b0, 1'b1);
    t_collision();
    send_chk(8'h5A, 1'b0, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule